// File: doc/BRIEF.md
# Sub-Second Time Base with Fractional Shift

This block is the seconds time base of a real-time clock. An enable that pulses at the reference rate (nominally 32768 Hz) drives a small asynchronous down-divider. Each time that divider wraps it steps a 16-bit synchronous down-counter. When the counter wraps it emits a one-cycle seconds tick. With a divide of (async_div+1)·(sync_div+1) = 32768 the tick runs at 1 Hz. The live synchronous count is the sub-second reading, so time resolves to 1/(sync_div+1) s. A sync_div of 0x7FFF gives about 30.5 µs, but then async_div must be 0 to keep the tick at 1 Hz.

Software can move time by a fraction of a second. A shift request captures a 15-bit fraction and an advance flag, and raises a busy flag. At the next prescaler step the fraction is added to the sub-second counter, which delays the clock by that many sub-second steps. When the advance flag is set, an extra seconds tick is issued at the same step, so the net move is one second minus the fraction. The busy flag drops once the shift has been applied.

Top module: `rtc_subsec_timebase`

## Requirements
- R1: After the asynchronous active-low reset, subsec is 0 and sec_tick and shift_busy are 0.
- R2: A prescaler step occurs on a clock edge where ref_en is 1 and the async divider is 0, after which the divider reloads async_div. On other ref_en edges it counts down by one. This gives one step per async_div+1 enabled edges. While ref_en is 0, nothing in the time base changes.
- R3: On each prescaler step the sub-second counter counts down by one. From 0 it reloads sync_div instead, and sec_tick is 1 for the single cycle after that reload edge.
- R4: subsec always shows the synchronous counter. Bit 15 is set only when a shift has pushed the count past 0x7FFF.
- R5: A request (shift_req=1) is accepted when shift_busy is 0 and subsec[15] is 0. Acceptance captures shift_frac and shift_adv and sets shift_busy after that edge.
- R6: A pending shift is applied on the next prescaler step at which the counter is non-zero. At that step the counter becomes old−1+fraction, and shift_busy clears.
- R7: If the captured advance flag is 1, sec_tick is also 1 in the cycle after the step that applies the shift.
- R8: A request made while shift_busy is 1 is ignored. The pending fraction and advance flag are unchanged.
- R9: A request made while subsec[15] is 1 is ignored, and shift_busy stays 0.
- R10: If the counter is 0 at the step, the shift is deferred. The counter reloads and ticks as usual, shift_busy stays 1, and the shift is applied at the following step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | One-cycle pulse per reference clock period |
| async_div | input | 7 | Asynchronous divide value minus one |
| sync_div | input | 15 | Synchronous divide value minus one |
| shift_req | input | 1 | Shift request strobe |
| shift_frac | input | 15 | Fraction, in sub-second steps, added to the counter |
| shift_adv | input | 1 | Turn the shift into an advance by adding one second |
| sec_tick | output | 1 | One-cycle seconds tick |
| subsec | output | 16 | Current sub-second counter |
| shift_busy | output | 1 | Shift pending |

## Verification
All three outputs are registered, so each result is due on the first clock edge after the edge that causes it. The bench drives inputs and reads outputs at the falling edge, one rising edge after the stimulus. A request raises shift_busy one edge after it is made. Its effect on subsec, and any advance tick, appears one prescaler step later. That step is the next edge when ref_en is held high with async_div 0. Deferral adds one further step. The bench counts ticks at every falling edge, so a tick that comes early, late or twice is caught.

// File: rtl/rtc_subsec_timebase.sv
module rtc_subsec_timebase #(
  parameter int ADIV_W = 7,
  parameter int SDIV_W = 15,
  localparam int SS_W = SDIV_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic [ADIV_W-1:0] async_div,
  input  logic [SDIV_W-1:0] sync_div,
  input  logic              shift_req,
  input  logic [SDIV_W-1:0] shift_frac,
  input  logic              shift_adv,
  output logic              sec_tick,
  output logic [SS_W-1:0]   subsec,
  output logic              shift_busy
);

  logic [ADIV_W-1:0] acnt;
  logic [SS_W-1:0]   scnt;
  logic [SDIV_W-1:0] frac_q;
  logic              adv_q, pend, tick_q;

  wire step   = ref_en && (acnt == '0);
  wire wrap   = (scnt == '0);
  wire apply  = step && pend && !wrap;
  wire accept = shift_req && !pend && !scnt[SS_W-1];

  wire [SS_W-1:0] base = wrap ? {1'b0, sync_div} : scnt - 1'b1;
  wire [SS_W-1:0] addn = apply ? {1'b0, frac_q} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt   <= '0;
      scnt   <= '0;
      frac_q <= '0;
      adv_q  <= 1'b0;
      pend   <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (ref_en)
        acnt <= step ? async_div : acnt - 1'b1;
      if (step)
        scnt <= base + addn;
      tick_q <= step && (wrap || (apply && adv_q));
      if (apply)
        pend <= 1'b0;
      else if (accept) begin
        pend   <= 1'b1;
        frac_q <= shift_frac;
        adv_q  <= shift_adv;
      end
    end
  end

  assign sec_tick   = tick_q;
  assign subsec     = scnt;
  assign shift_busy = pend;

endmodule

// File: rtl/rtc_subsec_timebase_chk.sv
module rtc_subsec_timebase_chk #(
  parameter int SDIV_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_en,
  input logic [SDIV_W-1:0] sync_div,
  input logic              shift_req,
  input logic              sec_tick,
  input logic [SDIV_W:0]   subsec,
  input logic              shift_busy
);

  // R2
  a_r2_frozen_without_ref: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |=> $stable(subsec));

  // R3
  a_r3_tick_after_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !$past(shift_busy)) |-> subsec == {1'b0, $past(sync_div)});

  // R5
  a_r5_request_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_req && !shift_busy && !subsec[SDIV_W]) |=> shift_busy);

  // R9
  a_r9_busy_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_busy && !(shift_req && !subsec[SDIV_W])) |=> !shift_busy);

  // R6
  a_r6_pending_held_without_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_busy && !ref_en) |=> shift_busy);

  // R10
  a_r10_no_apply_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_busy) |-> $past(subsec) != '0);

endmodule

bind rtc_subsec_timebase rtc_subsec_timebase_chk #(.SDIV_W(SDIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .sync_div(sync_div),
  .shift_req(shift_req), .sec_tick(sec_tick), .subsec(subsec),
  .shift_busy(shift_busy)
);

// File: tb/test_rtc_subsec_timebase.sv
`timescale 1ns/1ps
module test_rtc_subsec_timebase;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0;
  logic [6:0]  async_div = '0;
  logic [14:0] sync_div = '0;
  logic        shift_req = 1'b0;
  logic [14:0] shift_frac = '0;
  logic        shift_adv = 1'b0;
  logic        sec_tick;
  logic [15:0] subsec;
  logic        shift_busy;

  int nvec = 0;
  int nbad = 0;
  int ticks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_subsec_timebase i_rtc_subsec_timebase (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .async_div(async_div),
    .sync_div(sync_div), .shift_req(shift_req), .shift_frac(shift_frac),
    .shift_adv(shift_adv), .sec_tick(sec_tick), .subsec(subsec),
    .shift_busy(shift_busy)
  );

  // {ref_en, async_div, sync_div, edges, exp_subsec, exp_ticks}
  localparam int NV = 11;
  localparam logic [54:0] VEC [NV] = '{
    {1'b1, 7'd0, 15'd3, 8'd1, 16'd3, 8'd1},
    {1'b1, 7'd0, 15'd3, 8'd2, 16'd1, 8'd0},
    {1'b1, 7'd0, 15'd3, 8'd1, 16'd0, 8'd0},
    {1'b1, 7'd0, 15'd3, 8'd1, 16'd3, 8'd1},
    {1'b1, 7'd0, 15'd3, 8'd4, 16'd3, 8'd1},
    {1'b0, 7'd0, 15'd3, 8'd3, 16'd3, 8'd0},
    {1'b1, 7'd2, 15'd3, 8'd4, 16'd1, 8'd0},
    {1'b1, 7'd2, 15'd3, 8'd2, 16'd1, 8'd0},
    {1'b1, 7'd2, 15'd3, 8'd1, 16'd0, 8'd0},
    {1'b1, 7'd2, 15'd3, 8'd2, 16'd0, 8'd0},
    {1'b1, 7'd2, 15'd3, 8'd1, 16'd3, 8'd1}
  };

  task automatic chk(string req, string what, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (sec_tick) ticks++;
    end
  endtask

  task automatic do_reset();
    shift_req = 1'b0;
    ref_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ticks = 0;
  endtask

  task automatic request(logic [14:0] f, logic a);
    shift_req = 1'b1; shift_frac = f; shift_adv = a;
    step(1);
    shift_req = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1", "subsec", subsec, 0);
    chk("R1", "tick", sec_tick, 0);
    chk("R1", "busy", shift_busy, 0);

    // R2 R3 R4: divider and counter sequences
    for (int v = 0; v < NV; v++) begin
      ref_en = VEC[v][54];
      async_div = VEC[v][53:47];
      sync_div = VEC[v][46:32];
      ticks = 0;
      step(int'(VEC[v][31:24]));
      chk("R3", $sformatf("vec%0d subsec", v), subsec, int'(VEC[v][23:8]));
      chk("R2", $sformatf("vec%0d ticks", v), ticks, int'(VEC[v][7:0]));
    end

    // R5 R6: delay shift
    do_reset();
    ref_en = 1'b1; async_div = 0; sync_div = 7;
    step(1);
    chk("R3", "reload", subsec, 7);
    request(15'd5, 1'b0);
    chk("R5", "busy", shift_busy, 1);
    chk("R5", "subsec", subsec, 6);
    ticks = 0;
    step(1);
    chk("R6", "subsec", subsec, 10);
    chk("R6", "busy", shift_busy, 0);
    step(10);
    chk("R6", "subsec", subsec, 0);
    chk("R6", "ticks", ticks, 0);
    step(1);
    chk("R6", "late tick", ticks, 1);
    chk("R3", "reload", subsec, 7);

    // R7: advance
    request(15'd3, 1'b1);
    chk("R7", "subsec", subsec, 6);
    ticks = 0;
    step(1);
    chk("R7", "subsec", subsec, 8);
    chk("R7", "tick", ticks, 1);
    chk("R7", "busy", shift_busy, 0);

    // R8: request while busy ignored
    ref_en = 1'b0;
    request(15'd2, 1'b0);
    chk("R8", "busy", shift_busy, 1);
    chk("R2", "frozen", subsec, 8);
    request(15'd9, 1'b1);
    ref_en = 1'b1;
    ticks = 0;
    step(1);
    chk("R8", "subsec", subsec, 9);
    chk("R8", "tick", ticks, 0);

    // R9: overflow guard
    do_reset();
    ref_en = 1'b1; async_div = 0; sync_div = 15'h7FFF;
    step(1);
    request(15'h7FFF, 1'b0);
    step(1);
    chk("R4", "subsec", subsec, 16'hFFFC);
    request(15'd1, 1'b0);
    chk("R9", "busy", shift_busy, 0);
    chk("R9", "subsec", subsec, 16'hFFFB);
    step(1);
    chk("R9", "subsec", subsec, 16'hFFFA);

    // R10: deferral at zero
    do_reset();
    ref_en = 1'b1; async_div = 0; sync_div = 3;
    step(3);
    chk("R10", "subsec", subsec, 1);
    request(15'd2, 1'b0);
    chk("R10", "subsec", subsec, 0);
    ticks = 0;
    step(1);
    chk("R10", "subsec", subsec, 3);
    chk("R10", "busy", shift_busy, 1);
    chk("R10", "tick", ticks, 1);
    step(1);
    chk("R10", "subsec", subsec, 4);
    chk("R10", "busy", shift_busy, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule